// File: doc/BRIEF.md
# External Interrupt Request Detector

This block conditions a set of asynchronous, active-low external interrupt pins for a small processor core. Each pin is first brought into the clock domain by a two-stage synchroniser. It is then sampled only when the core's machine-cycle strobe is high. A mode bit per input selects how that input raises a request:

- **Edge mode** detects a falling transition between two consecutive machine-cycle samples and holds a request flag. The flag is cleared when the core acknowledges that input's vector, or when software writes it.
- **Level mode** makes the flag follow the most recent sample, with no storage. It is asserted while the pin reads low.

The flags go to a separate interrupt controller, which performs arbitration.

The block also produces a registered wake-up output for the core's low-power states. In idle, the wake-up is driven by any enabled input whose request flag is active. In power-down, the machine-cycle strobe may be stopped. There, the wake-up is also driven by the synchronised low level of any enabled pin, so no strobe is needed.

Top module: `extint_detect`

## Requirements
- R1: Immediately after reset, every bit of `reqFlag` is 0 and `wakeUp` is 0. Each input's last-sample register resets to high.
- R2: A pin change is taken into the block only at a clock edge where `cycStrobe` is 1. Without a strobe, `reqFlag` does not change however long the pin stays at its new level.
- R3: In edge mode (`levelMode[i]`=0), a strobe sample of 0 that follows a strobe sample of 1 sets `reqFlag[i]` at that strobe's clock edge.
- R4: In edge mode, a low pulse that both starts and ends between two strobes, with both strobes sampling high, leaves `reqFlag[i]` at 0.
- R5: In edge mode, a one-cycle `ackValid` pulse clears `reqFlag[i]` at the next edge, but only when `ackIdx` equals i. The flags of other inputs are unchanged.
- R6: In level mode (`levelMode[i]`=1), `reqFlag[i]` is the inverse of the last strobe sample, and it goes 1 and 0 with the pin. An acknowledge for that input has no effect on it.
- R7: In edge mode, a write with `swWrEn`=1 sets or clears `reqFlag[swWrIdx]` to `swWrVal`. A hardware edge in the same cycle as a software clear leaves the flag at 1.
- R8: With `idleMode`=1, `wakeUp` is 1 one clock after some input i has both `intEn[i]`=1 and `reqFlag[i]`=1. A flag on a disabled input does not wake.
- R9: With `pdMode`=1, an enabled input whose synchronised pin is low drives `wakeUp` to 1 without any strobe. `wakeUp` returns to 0 once that pin is high again.
- R10: With `idleMode`=0 and `pdMode`=0, `wakeUp` stays 0 whatever the flags are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cycStrobe | input | 1 | One-clock pulse marking a machine cycle |
| pinN | input | NUM_IN | Asynchronous active-low interrupt pins |
| levelMode | input | NUM_IN | 1 = level mode, 0 = falling-edge mode, per input |
| intEn | input | NUM_IN | Per-input enable for the wake-up path |
| ackValid | input | 1 | One-cycle vector acknowledge from the core |
| ackIdx | input | IDX_W | Index of the input being acknowledged |
| swWrEn | input | 1 | Software write strobe for an edge-mode flag |
| swWrIdx | input | IDX_W | Index of the flag being written |
| swWrVal | input | 1 | Value written to the flag |
| idleMode | input | 1 | Core is in idle |
| pdMode | input | 1 | Core is in power-down |
| reqFlag | output | NUM_IN | Request flags to the interrupt controller |
| wakeUp | output | 1 | Registered wake-up request |

## Verification
A wrong last-sample register shows up as a missing or spurious edge request. It becomes visible on `reqFlag` at the very next strobe that samples low, or in level mode at once as an inverted flag. A stuck edge flag or a misdecoded acknowledge index appears on `reqFlag` one clock after the acknowledge or software write. A fault in the wake-up qualification shows on `wakeUp` one clock after the flag, mode or pin condition changes. The bench therefore checks each output at a fixed clock count after each stimulus.

// File: rtl/extint_pkg.sv
package extint_pkg;

  // Per-input strobes sent from control to datapath
  typedef struct packed {
    logic sample;  // take a machine-cycle sample this clock
    logic ackClr;  // acknowledge clears the edge flag
    logic swSet;   // software sets the edge flag
    logic swClr;   // software clears the edge flag
  } laneCtl_t;

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[STAGES-2:0], asyncIn[b]};
    end
    assign syncOut[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/extint_ctrl.sv
module extint_ctrl
  import extint_pkg::*;
#(
  parameter int NUM_IN = 2,
  parameter int IDX_W  = 1
) (
  input  logic              cycStrobe,
  input  logic [NUM_IN-1:0] levelMode,
  input  logic              ackValid,
  input  logic [IDX_W-1:0]  ackIdx,
  input  logic              swWrEn,
  input  logic [IDX_W-1:0]  swWrIdx,
  input  logic              swWrVal,
  output laneCtl_t          laneCtl [NUM_IN]
);

  for (genvar i = 0; i < NUM_IN; i++) begin : g_lane
    logic ackHit;
    logic wrHit;
    logic edgeLane;
    always_comb begin
      edgeLane = ~levelMode[i];
      ackHit   = ackValid && (ackIdx == IDX_W'(i));
      wrHit    = swWrEn && (swWrIdx == IDX_W'(i));
      laneCtl[i].sample = cycStrobe;
      laneCtl[i].ackClr = ackHit && edgeLane;
      laneCtl[i].swSet  = wrHit && swWrVal && edgeLane;
      laneCtl[i].swClr  = wrHit && !swWrVal && edgeLane;
    end
  end

endmodule

// File: rtl/extint_datapath.sv
module extint_datapath
  import extint_pkg::*;
#(
  parameter int NUM_IN = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] syncPin,
  input  logic [NUM_IN-1:0] levelMode,
  input  logic [NUM_IN-1:0] intEn,
  input  logic              idleMode,
  input  logic              pdMode,
  input  laneCtl_t          laneCtl [NUM_IN],
  output logic [NUM_IN-1:0] reqFlag,
  output logic              wakeUp
);

  logic [NUM_IN-1:0] lastSample;
  logic [NUM_IN-1:0] edgeFlag;
  logic [NUM_IN-1:0] wakeSrc;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_lane
    logic hwSet;
    assign hwSet = laneCtl[i].sample && !levelMode[i] && lastSample[i] && !syncPin[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lastSample[i] <= 1'b1;
        edgeFlag[i]   <= 1'b0;
      end else begin
        if (laneCtl[i].sample) lastSample[i] <= syncPin[i];
        if (hwSet)                                   edgeFlag[i] <= 1'b1;
        else if (laneCtl[i].swSet)                   edgeFlag[i] <= 1'b1;
        else if (laneCtl[i].swClr || laneCtl[i].ackClr) edgeFlag[i] <= 1'b0;
      end
    end

    assign reqFlag[i] = levelMode[i] ? !lastSample[i] : edgeFlag[i];
    assign wakeSrc[i] = intEn[i] &&
                        ((idleMode && reqFlag[i]) ||
                         (pdMode && (reqFlag[i] || !syncPin[i])));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wakeUp <= 1'b0;
    else       wakeUp <= |wakeSrc;
  end

endmodule

// File: rtl/extint_detect.sv
module extint_detect
  import extint_pkg::*;
#(
  parameter int NUM_IN = 2,
  localparam int IDX_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycStrobe,
  input  logic [NUM_IN-1:0] pinN,
  input  logic [NUM_IN-1:0] levelMode,
  input  logic [NUM_IN-1:0] intEn,
  input  logic              ackValid,
  input  logic [IDX_W-1:0]  ackIdx,
  input  logic              swWrEn,
  input  logic [IDX_W-1:0]  swWrIdx,
  input  logic              swWrVal,
  input  logic              idleMode,
  input  logic              pdMode,
  output logic [NUM_IN-1:0] reqFlag,
  output logic              wakeUp
);

  logic [NUM_IN-1:0] syncPin;
  laneCtl_t          laneCtl [NUM_IN];

  extint_sync #(.WIDTH(NUM_IN), .STAGES(2)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(pinN), .syncOut(syncPin)
  );

  extint_ctrl #(.NUM_IN(NUM_IN), .IDX_W(IDX_W)) u_ctrl (
    .cycStrobe(cycStrobe), .levelMode(levelMode),
    .ackValid(ackValid), .ackIdx(ackIdx),
    .swWrEn(swWrEn), .swWrIdx(swWrIdx), .swWrVal(swWrVal),
    .laneCtl(laneCtl)
  );

  extint_datapath #(.NUM_IN(NUM_IN)) u_dp (
    .clk(clk), .rstN(rstN), .syncPin(syncPin), .levelMode(levelMode),
    .intEn(intEn), .idleMode(idleMode), .pdMode(pdMode),
    .laneCtl(laneCtl), .reqFlag(reqFlag), .wakeUp(wakeUp)
  );

endmodule

// File: rtl/extint_detect_chk.sv
module extint_detect_chk #(
  parameter int NUM_IN = 2,
  parameter int IDX_W  = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              cycStrobe,
  input logic [NUM_IN-1:0] syncPin,
  input logic [NUM_IN-1:0] levelMode,
  input logic              ackValid,
  input logic [IDX_W-1:0]  ackIdx,
  input logic              swWrEn,
  input logic [IDX_W-1:0]  swWrIdx,
  input logic              swWrVal,
  input logic              idleMode,
  input logic              pdMode,
  input logic [NUM_IN-1:0] reqFlag,
  input logic              wakeUp
);

  for (genvar i = 0; i < NUM_IN; i++) begin : g_lane
    AST_NO_FLAG_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rstN)
      (!$past(cycStrobe) && !$past(swWrEn) && $stable(levelMode[i])) |-> !$rose(reqFlag[i])); // R2

    AST_EDGE_SET_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
      (!levelMode[i] && $past(!levelMode[i]) && $rose(reqFlag[i])) |->
        ($past(cycStrobe) || $past(swWrEn && swWrIdx == IDX_W'(i) && swWrVal))); // R3

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
      ($past(ackValid && ackIdx == IDX_W'(i) && !levelMode[i] && !cycStrobe && !swWrEn)
        && !levelMode[i]) |-> !reqFlag[i]); // R5

    AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rstN)
      ($past(cycStrobe) && levelMode[i] && $past(levelMode[i])) |-> (reqFlag[i] == !$past(syncPin[i]))); // R6
  end

  AST_NO_WAKE_AWAKE: assert property (@(posedge clk) disable iff (!rstN)
    $past(!idleMode && !pdMode) |-> !wakeUp); // R10

endmodule

bind extint_detect extint_detect_chk #(.NUM_IN(NUM_IN), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .cycStrobe(cycStrobe), .syncPin(syncPin),
  .levelMode(levelMode), .ackValid(ackValid), .ackIdx(ackIdx),
  .swWrEn(swWrEn), .swWrIdx(swWrIdx), .swWrVal(swWrVal),
  .idleMode(idleMode), .pdMode(pdMode), .reqFlag(reqFlag), .wakeUp(wakeUp)
);

// File: tb/extint_detect_tb.sv
`timescale 1ns/1ps
module extint_detect_tb;

  localparam int NUM_IN = 2;
  localparam int IDX_W  = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cycStrobe = 1'b0;
  logic [NUM_IN-1:0] pinN = '1;
  logic [NUM_IN-1:0] levelMode = '0;
  logic [NUM_IN-1:0] intEn = '0;
  logic ackValid = 1'b0;
  logic [IDX_W-1:0] ackIdx = '0;
  logic swWrEn = 1'b0;
  logic [IDX_W-1:0] swWrIdx = '0;
  logic swWrVal = 1'b0;
  logic idleMode = 1'b0;
  logic pdMode = 1'b0;
  logic [NUM_IN-1:0] reqFlag;
  logic wakeUp;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  extint_detect #(.NUM_IN(NUM_IN)) u_dut (
    .clk(clk), .rstN(rstN), .cycStrobe(cycStrobe), .pinN(pinN),
    .levelMode(levelMode), .intEn(intEn), .ackValid(ackValid), .ackIdx(ackIdx),
    .swWrEn(swWrEn), .swWrIdx(swWrIdx), .swWrVal(swWrVal),
    .idleMode(idleMode), .pdMode(pdMode), .reqFlag(reqFlag), .wakeUp(wakeUp)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle();   // pin through the synchroniser
    repeat (3) @(negedge clk);
  endtask

  task automatic strobe();
    @(negedge clk) cycStrobe = 1'b1;
    @(negedge clk) cycStrobe = 1'b0;
  endtask

  task automatic ack(input int idx);
    @(negedge clk) begin ackValid = 1'b1; ackIdx = IDX_W'(idx); end
    @(negedge clk) ackValid = 1'b0;
  endtask

  task automatic swWrite(input int idx, input logic val);
    @(negedge clk) begin swWrEn = 1'b1; swWrIdx = IDX_W'(idx); swWrVal = val; end
    @(negedge clk) swWrEn = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 flags", 32'(reqFlag), 0);
    check("R1 wake", 32'(wakeUp), 0);
  endtask

  task automatic t_edge();
    pinN[0] = 1'b0; settle(); repeat (4) @(negedge clk);
    check("R2 no strobe", 32'(reqFlag), 0);
    strobe();
    check("R3 edge set", 32'(reqFlag), 32'b01);
    ack(1);
    check("R5 other idx", 32'(reqFlag), 32'b01);
    ack(0);
    check("R5 ack clear", 32'(reqFlag), 0);
  endtask

  task automatic t_narrow();
    pinN[0] = 1'b1; settle(); strobe();
    @(negedge clk) pinN[0] = 1'b0;
    repeat (2) @(negedge clk);
    pinN[0] = 1'b1; settle(); strobe();
    check("R4 narrow missed", 32'(reqFlag), 0);
  endtask

  task automatic t_level();
    levelMode[1] = 1'b1;
    pinN[1] = 1'b0; settle(); strobe();
    check("R6 level low", 32'(reqFlag), 32'b10);
    ack(1);
    check("R6 ack ignored", 32'(reqFlag), 32'b10);
    pinN[1] = 1'b1; settle(); strobe();
    check("R6 level high", 32'(reqFlag), 0);
    levelMode[1] = 1'b0;
  endtask

  task automatic t_sw();
    swWrite(0, 1'b1);
    check("R7 sw set", 32'(reqFlag), 32'b01);
    swWrite(0, 1'b0);
    check("R7 sw clr", 32'(reqFlag), 0);
    pinN[0] = 1'b0; settle();
    @(negedge clk) begin cycStrobe = 1'b1; swWrEn = 1'b1; swWrIdx = 0; swWrVal = 1'b0; end
    @(negedge clk) begin cycStrobe = 1'b0; swWrEn = 1'b0; end
    check("R7 hw beats clr", 32'(reqFlag), 32'b01);
    pinN[0] = 1'b1; settle(); strobe();
    check("R7 flag held", 32'(reqFlag), 32'b01);
  endtask

  task automatic t_idle();
    idleMode = 1'b1; intEn = 2'b10;
    repeat (2) @(negedge clk);
    check("R8 disabled no wake", 32'(wakeUp), 0);
    intEn = 2'b01;
    repeat (2) @(negedge clk);
    check("R8 idle wake", 32'(wakeUp), 1);
    idleMode = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 awake no wake", 32'(wakeUp), 0);
    ack(0);
    check("R5 clear before pd", 32'(reqFlag), 0);
  endtask

  task automatic t_pd();
    pdMode = 1'b1; intEn = 2'b10;
    pinN[1] = 1'b0; settle();
    check("R9 pd level wake", 32'(wakeUp), 1);
    check("R2 pd no flag", 32'(reqFlag), 0);
    pinN[1] = 1'b1; settle();
    check("R9 pd release", 32'(wakeUp), 0);
    pdMode = 1'b0; intEn = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_edge();
    t_narrow();
    t_level();
    t_sw();
    t_idle();
    t_pd();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule